// File: doc/BRIEF.md
# Precise Exception Tracking Unit

This unit follows every instruction of a five-stage integer pipeline (fetch, decode, execute, memory, writeback) and keeps, beside each instruction, a small vector of the faults it has raised so far. A fault is only posted when a stage detects it: a fetch page fault, an undefined opcode at decode, a division by zero at execute, or a data page fault or protection violation at memory access. Nothing reacts at detection time. The vector is examined when the instruction leaves the memory stage, and only there does a trap begin. Exceptions are therefore taken in program order: an older instruction's late fault is always serviced before a younger instruction's earlier one.

When a trap is taken, the unit records the PC of the faulting instruction and a cause code. It suppresses the store and the register write of that instruction, discards every younger instruction, and steers the next fetch to a fixed handler address. A return-from-trap pulse sends fetch back to the saved PC. The unit samples an external interrupt line every cycle. When the interrupt is taken, the instruction in the memory stage completes, younger work is discarded, and the PC of the oldest unfinished instruction is saved. The unit also owns the fetch PC, which advances by 4 on every fetch request.

Top module: `precise_exc_unit`

## Requirements
- R1: A fault is carried with its instruction and never acted on before that instruction reaches the memory stage. A fault raised at fetch in cycle c produces `exc_take` in cycle c+3, and not earlier.
- R2: The cause code is 3 bits wide. 1 means fetch page fault, 2 undefined opcode, 3 division by zero, 4 data page fault, 5 protection violation, 6 interrupt, and 0 means none since reset. When one instruction has several faults, the fault from the earliest stage gives the code. Within the memory stage, the page fault outranks the protection violation.
- R3: On an exception, `epc` takes the PC of the faulting instruction in the cycle after `exc_take`.
- R4: When an older instruction faults at memory and a younger one has already faulted at fetch, the older fault is the one taken. The younger instruction never traps.
- R5: In the cycle where the faulting instruction leaves memory, `store_en` and `retire_valid` are low. No younger instruction that was in the pipe at that time ever reaches memory.
- R6: An instruction without faults that leaves memory raises `retire_valid`, with its PC on `mem_pc`. It raises `store_en` when it requests a store.
- R7: After an exception or an interrupt is taken, `fetch_pc` equals `HANDLER_PC`.
- R8: A return-from-trap pulse that is not overridden by an exception loads `fetch_pc` from `epc`. Fetch then continues sequentially from that PC, and the first instruction fetched reaches memory three cycles after it is fetched.
- R9: An interrupt is taken when no exception commits and no return is pending, and only while not inside a handler. The instruction in memory retires. `epc` gets the PC of the oldest unfinished instruction: execute stage, else decode stage, else `fetch_pc`. The cause becomes 6.
- R10: An exception that commits in the same cycle as a pending interrupt wins. A return-from-trap also outranks the interrupt. The interrupt is taken on a later cycle.
- R11: After reset, `fetch_pc` equals `RESET_PC`, `epc` and `cause` are 0, and no retire, store or trap is signalled.
- R12: `fetch_pc` advances by 4 in each cycle with `fetch_req` high and holds in a cycle with it low. A cycle with `fetch_req` low places a bubble that retires nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | An instruction is fetched at `fetch_pc` this cycle |
| if_fault | input | 1 | Fetch page fault on this cycle's fetch |
| id_illegal | input | 1 | Undefined opcode for the instruction in decode |
| ex_divzero | input | 1 | Division by zero for the instruction in execute |
| mem_pgfault | input | 1 | Data page fault for the instruction in memory |
| mem_protfault | input | 1 | Protection violation for the instruction in memory |
| mem_store_req | input | 1 | The instruction in memory wants to store |
| irq | input | 1 | External interrupt request, level |
| trap_return | input | 1 | Return-from-trap is committing |
| fetch_pc | output | AW | PC of the next fetch |
| redirect | output | 1 | Pipe flush and fetch redirect this cycle |
| exc_take | output | 1 | An exception commits this cycle |
| irq_take | output | 1 | An interrupt is taken this cycle |
| epc | output | AW | Saved exception PC |
| cause | output | 3 | Recorded cause code |
| store_en | output | 1 | Store permitted for the instruction in memory |
| retire_valid | output | 1 | Instruction leaves memory and will write back |
| mem_pc | output | AW | PC of the instruction in memory |

## Verification
The hardest situation to reach from the ports is two faults in flight at once, where the younger instruction's fault was detected first and must lose. Directed sequences reach it by fetching a faulting instruction right behind a clean one, then raising a memory-stage fault on the older one three cycles later. The bench then confirms that no second trap follows. A similar timed sequence lines up an interrupt with a committing exception, and then with a return pulse, to show the interrupt is deferred rather than lost.

// File: rtl/pet_pkg.sv
package pet_pkg;

  localparam int VEC_W = 5;

  typedef logic [VEC_W-1:0] exc_vec_t;

  typedef enum logic [2:0] {
    CAUSE_NONE      = 3'd0,
    CAUSE_IFETCH_PF = 3'd1,
    CAUSE_BAD_OP    = 3'd2,
    CAUSE_DIV0      = 3'd3,
    CAUSE_DATA_PF   = 3'd4,
    CAUSE_DATA_PROT = 3'd5,
    CAUSE_IRQ       = 3'd6
  } cause_e;

  // Lowest set bit wins: bit index grows with stage, so earliest stage first.
  function automatic cause_e cause_of(exc_vec_t v);
    cause_e c;
    c = CAUSE_NONE;
    for (int i = VEC_W - 1; i >= 0; i--) begin
      if (v[i]) c = cause_e'(i + 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/pet_stage.sv
module pet_stage
  import pet_pkg::*;
#(
  parameter int AW   = 32,
  parameter int FBIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  input  logic [AW-1:0] in_pc,
  input  exc_vec_t      in_vec,
  input  logic          fault,
  output logic          out_valid,
  output logic [AW-1:0] out_pc,
  output exc_vec_t      out_vec
);

  // Post this stage's fault into the travelling vector.
  function automatic exc_vec_t post(exc_vec_t v, logic f);
    return v | (exc_vec_t'(f) << FBIT);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pc    <= '0;
      out_vec   <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= in_valid;
      out_pc    <= in_pc;
      out_vec   <= in_valid ? post(in_vec, fault) : '0;
    end
  end

endmodule

// File: rtl/pet_commit.sv
module pet_commit
  import pet_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          mem_valid,
  input  exc_vec_t      mem_vec,
  input  logic          mem_pgfault,
  input  logic          mem_protfault,
  input  logic          irq,
  input  logic          trap_return,
  input  logic          in_handler,
  input  logic          ex_valid,
  input  logic [AW-1:0] ex_pc,
  input  logic          id_valid,
  input  logic [AW-1:0] id_pc,
  input  logic [AW-1:0] fetch_pc,
  output logic          exc_take,
  output logic          rft_take,
  output logic          irq_take,
  output cause_e        take_cause,
  output logic [AW-1:0] resume_pc
);

  exc_vec_t full_vec;

  // Oldest instruction not yet retired when an interrupt cuts in.
  function automatic logic [AW-1:0] oldest_open(logic exv, logic [AW-1:0] expc,
                                                logic idv, logic [AW-1:0] idpc,
                                                logic [AW-1:0] fpc);
    if (exv) return expc;
    if (idv) return idpc;
    return fpc;
  endfunction

  always_comb begin
    full_vec   = mem_valid ? (mem_vec | {mem_protfault, mem_pgfault, 3'b000}) : '0;
    exc_take   = mem_valid && (full_vec != '0);
    rft_take   = trap_return && !exc_take;
    irq_take   = irq && !in_handler && !exc_take && !trap_return;
    take_cause = exc_take ? cause_of(full_vec) : CAUSE_IRQ;
    resume_pc  = oldest_open(ex_valid, ex_pc, id_valid, id_pc, fetch_pc);
  end

endmodule

// File: rtl/pet_trap_state.sv
module pet_trap_state
  import pet_pkg::*;
#(
  parameter int          AW         = 32,
  parameter logic [AW-1:0] RESET_PC   = '0,
  parameter logic [AW-1:0] HANDLER_PC = 'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_take,
  input  logic          rft_take,
  input  logic          irq_take,
  input  cause_e        take_cause,
  input  logic [AW-1:0] mem_pc,
  input  logic [AW-1:0] resume_pc,
  input  logic          fetch_req,
  output logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] epc,
  output cause_e        cause,
  output logic          in_handler
);

  function automatic logic [AW-1:0] seq_pc(logic [AW-1:0] pc);
    return pc + AW'(4);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_pc   <= RESET_PC;
      epc        <= '0;
      cause      <= CAUSE_NONE;
      in_handler <= 1'b0;
    end else if (exc_take) begin
      epc        <= mem_pc;
      cause      <= take_cause;
      fetch_pc   <= HANDLER_PC;
      in_handler <= 1'b1;
    end else if (rft_take) begin
      fetch_pc   <= epc;
      in_handler <= 1'b0;
    end else if (irq_take) begin
      epc        <= resume_pc;
      cause      <= CAUSE_IRQ;
      fetch_pc   <= HANDLER_PC;
      in_handler <= 1'b1;
    end else if (fetch_req) begin
      fetch_pc   <= seq_pc(fetch_pc);
    end
  end

endmodule

// File: rtl/precise_exc_unit.sv
module precise_exc_unit
  import pet_pkg::*;
#(
  parameter int          AW         = 32,
  parameter logic [AW-1:0] RESET_PC   = '0,
  parameter logic [AW-1:0] HANDLER_PC = 'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_req,
  input  logic          if_fault,
  input  logic          id_illegal,
  input  logic          ex_divzero,
  input  logic          mem_pgfault,
  input  logic          mem_protfault,
  input  logic          mem_store_req,
  input  logic          irq,
  input  logic          trap_return,
  output logic [AW-1:0] fetch_pc,
  output logic          redirect,
  output logic          exc_take,
  output logic          irq_take,
  output logic [AW-1:0] epc,
  output logic [2:0]    cause,
  output logic          store_en,
  output logic          retire_valid,
  output logic [AW-1:0] mem_pc
);

  localparam int NREG = 3;  // IF/ID, ID/EX, EX/MEM
  localparam int ID_S = 0;
  localparam int EX_S = 1;
  localparam int MEM_S = NREG - 1;

  logic          st_in_valid [NREG];
  logic [AW-1:0] st_in_pc    [NREG];
  exc_vec_t      st_in_vec   [NREG];
  logic          st_fault    [NREG];
  logic          st_valid    [NREG];
  logic [AW-1:0] st_pc       [NREG];
  exc_vec_t      st_vec      [NREG];

  logic          rft_take;
  logic          in_handler;
  cause_e        take_cause;
  cause_e        cause_q;
  logic [AW-1:0] resume_pc;

  for (genvar k = 0; k < NREG; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_comb begin
        st_in_valid[k] = fetch_req;
        st_in_pc[k]    = fetch_pc;
        st_in_vec[k]   = '0;
        st_fault[k]    = if_fault;
      end
    end else begin : g_next
      always_comb begin
        st_in_valid[k] = st_valid[k-1];
        st_in_pc[k]    = st_pc[k-1];
        st_in_vec[k]   = st_vec[k-1];
        st_fault[k]    = (k == 1) ? id_illegal : ex_divzero;
      end
    end

    pet_stage #(.AW(AW), .FBIT(k)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (redirect),
      .in_valid  (st_in_valid[k]),
      .in_pc     (st_in_pc[k]),
      .in_vec    (st_in_vec[k]),
      .fault     (st_fault[k]),
      .out_valid (st_valid[k]),
      .out_pc    (st_pc[k]),
      .out_vec   (st_vec[k])
    );
  end

  pet_commit #(.AW(AW)) u_commit (
    .mem_valid     (st_valid[MEM_S]),
    .mem_vec       (st_vec[MEM_S]),
    .mem_pgfault   (mem_pgfault),
    .mem_protfault (mem_protfault),
    .irq           (irq),
    .trap_return   (trap_return),
    .in_handler    (in_handler),
    .ex_valid      (st_valid[EX_S]),
    .ex_pc         (st_pc[EX_S]),
    .id_valid      (st_valid[ID_S]),
    .id_pc         (st_pc[ID_S]),
    .fetch_pc      (fetch_pc),
    .exc_take      (exc_take),
    .rft_take      (rft_take),
    .irq_take      (irq_take),
    .take_cause    (take_cause),
    .resume_pc     (resume_pc)
  );

  pet_trap_state #(.AW(AW), .RESET_PC(RESET_PC), .HANDLER_PC(HANDLER_PC)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_take   (exc_take),
    .rft_take   (rft_take),
    .irq_take   (irq_take),
    .take_cause (take_cause),
    .mem_pc     (st_pc[MEM_S]),
    .resume_pc  (resume_pc),
    .fetch_req  (fetch_req),
    .fetch_pc   (fetch_pc),
    .epc        (epc),
    .cause      (cause_q),
    .in_handler (in_handler)
  );

  always_comb begin
    redirect     = exc_take || rft_take || irq_take;
    retire_valid = st_valid[MEM_S] && !exc_take;
    store_en     = retire_valid && mem_store_req;
    mem_pc       = st_pc[MEM_S];
    cause        = cause_q;
  end

endmodule

// File: rtl/pet_checker.sv
module pet_checker #(
  parameter int          AW         = 32,
  parameter logic [AW-1:0] HANDLER_PC = 'h80
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exc_take,
  input logic          irq_take,
  input logic          rft_take,
  input logic [AW-1:0] fetch_pc,
  input logic [AW-1:0] epc,
  input logic [2:0]    cause,
  input logic [AW-1:0] mem_pc,
  input logic          retire_valid,
  input logic          store_en
);

  // R3: saved PC is the PC of the instruction that left memory with a fault
  a_r3_epc_from_mem: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> epc == $past(mem_pc));

  // R2: an exception records a stage cause code, never none or interrupt
  a_r2_cause_range: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (cause >= 3'd1 && cause <= 3'd5));

  // R7: fetch goes to the handler after any trap
  a_r7_handler_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take || irq_take) |=> fetch_pc == HANDLER_PC);

  // R5: younger instructions are gone, nothing leaves memory next cycle
  a_r5_flush_younger: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> !retire_valid);

  // R5/R6: a store only happens for an instruction that retires
  a_r5_store_needs_retire: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |-> retire_valid);

  // R8: return restores the saved PC
  a_r8_return_pc: assert property (@(posedge clk) disable iff (!rst_n)
    rft_take |=> fetch_pc == $past(epc));

  // R10: at most one redirect source per cycle
  a_r10_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_take, irq_take, rft_take}));

endmodule

bind precise_exc_unit pet_checker #(.AW(AW), .HANDLER_PC(HANDLER_PC)) u_pet_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .exc_take     (exc_take),
  .irq_take     (irq_take),
  .rft_take     (rft_take),
  .fetch_pc     (fetch_pc),
  .epc          (epc),
  .cause        (cause),
  .mem_pc       (mem_pc),
  .retire_valid (retire_valid),
  .store_en     (store_en)
);

// File: tb/precise_exc_unit_test.sv
module precise_exc_unit_test;

  localparam int          AW      = 32;
  localparam logic [31:0] HANDLER = 32'h80;

  localparam logic [8:0] F   = 9'h001;
  localparam logic [8:0] IFF = 9'h002;
  localparam logic [8:0] IDL = 9'h004;
  localparam logic [8:0] EXD = 9'h008;
  localparam logic [8:0] MPF = 9'h010;
  localparam logic [8:0] MPR = 9'h020;
  localparam logic [8:0] ST  = 9'h040;
  localparam logic [8:0] IRQ = 9'h080;
  localparam logic [8:0] RT  = 9'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_req, if_fault, id_illegal, ex_divzero, mem_pgfault, mem_protfault;
  logic mem_store_req, irq, trap_return;
  logic [AW-1:0] fetch_pc, epc, mem_pc;
  logic redirect, exc_take, irq_take, store_en, retire_valid;
  logic [2:0] cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  precise_exc_unit #(.AW(AW), .RESET_PC(32'h0), .HANDLER_PC(HANDLER)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .if_fault(if_fault),
    .id_illegal(id_illegal), .ex_divzero(ex_divzero), .mem_pgfault(mem_pgfault),
    .mem_protfault(mem_protfault), .mem_store_req(mem_store_req), .irq(irq),
    .trap_return(trap_return), .fetch_pc(fetch_pc), .redirect(redirect),
    .exc_take(exc_take), .irq_take(irq_take), .epc(epc), .cause(cause),
    .store_en(store_en), .retire_valid(retire_valid), .mem_pc(mem_pc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle's inputs shortly after a rising edge.
  task automatic set_in(input logic [8:0] v);
    fetch_req     = v[0];
    if_fault      = v[1];
    id_illegal    = v[2];
    ex_divzero    = v[3];
    mem_pgfault   = v[4];
    mem_protfault = v[5];
    mem_store_req = v[6];
    irq           = v[7];
    trap_return   = v[8];
    #2;
  endtask

  task automatic adv;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    set_in(9'h0);
    adv;
    adv;
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset_and_seq;
    do_reset;
    check("R11 fetch_pc", fetch_pc, 32'h0);
    check("R11 epc", epc, 32'h0);
    check("R11 cause", {29'b0, cause}, 32'h0);
    check("R11 retire", {31'b0, retire_valid}, 32'h0);
    check("R11 exc_take", {31'b0, exc_take}, 32'h0);
    set_in(F); adv;
    set_in(F); adv;
    set_in(9'h0); adv;
    check("R12 pc after bubble", fetch_pc, 32'h8);
    set_in(F | ST);
    check("R6 retire pc0", {31'b0, retire_valid}, 32'h1);
    check("R6 mem_pc pc0", mem_pc, 32'h0);
    check("R6 store pc0", {31'b0, store_en}, 32'h1);
    adv;
    set_in(F | ST);
    check("R6 mem_pc pc4", mem_pc, 32'h4);
    adv;
    set_in(ST);
    check("R12 bubble retire", {31'b0, retire_valid}, 32'h0);
    check("R12 bubble store", {31'b0, store_en}, 32'h0);
    adv;
    check("R12 pc held", fetch_pc, 32'h10);
  endtask

  task automatic t_fetch_fault_and_return;
    do_reset;
    set_in(F); adv;
    set_in(F | IFF); adv;
    set_in(F);
    check("R1 no early trap c2", {31'b0, exc_take}, 32'h0);
    adv;
    set_in(F | ST);
    check("R1 no early trap c3", {31'b0, exc_take}, 32'h0);
    check("R6 older retires", {31'b0, retire_valid}, 32'h1);
    adv;
    set_in(F | ST);
    check("R1 trap at c3 after fetch", {31'b0, exc_take}, 32'h1);
    check("R5 store blocked", {31'b0, store_en}, 32'h0);
    check("R5 no retire", {31'b0, retire_valid}, 32'h0);
    adv;
    check("R7 handler fetch", fetch_pc, HANDLER);
    check("R3 epc", epc, 32'h4);
    check("R2 cause fetch pf", {29'b0, cause}, 32'h1);
    for (int i = 0; i < 3; i++) begin
      set_in(ST);
      check("R5 younger flushed", {30'b0, retire_valid, store_en}, 32'h0);
      adv;
    end
    set_in(RT); adv;
    check("R8 return pc", fetch_pc, 32'h4);
    set_in(F); adv;
    check("R8 sequential", fetch_pc, 32'h8);
    set_in(F); adv;
    set_in(F); adv;
    set_in(9'h0);
    check("R8 resumed retire", {31'b0, retire_valid}, 32'h1);
    check("R8 resumed pc", mem_pc, 32'h4);
    adv;
  endtask

  task automatic t_single(input logic [8:0] m, input logic [2:0] exp_cause);
    do_reset;
    set_in(F | (m & IFF)); adv;
    set_in(m & IDL); adv;
    set_in(m & EXD); adv;
    set_in(m & (MPF | MPR));
    check("R2 trap taken", {31'b0, exc_take}, 32'h1);
    adv;
    check("R2 cause priority", {29'b0, cause}, {29'b0, exp_cause});
    check("R3 epc pc0", epc, 32'h0);
  endtask

  task automatic t_order;
    do_reset;
    set_in(F); adv;
    set_in(F | IFF); adv;
    set_in(9'h0); adv;
    set_in(MPR);
    check("R4 older trap", {31'b0, exc_take}, 32'h1);
    adv;
    check("R4 epc older", epc, 32'h0);
    check("R4 cause older", {29'b0, cause}, 32'h5);
    set_in(9'h0);
    check("R4 younger never traps", {31'b0, exc_take}, 32'h0);
    adv;
    check("R4 epc kept", epc, 32'h0);
  endtask

  task automatic t_interrupt;
    do_reset;
    set_in(F); adv;
    set_in(F); adv;
    set_in(F); adv;
    set_in(F | IRQ | ST);
    check("R9 irq taken", {31'b0, irq_take}, 32'h1);
    check("R9 mem retires", {31'b0, retire_valid}, 32'h1);
    check("R9 mem stores", {31'b0, store_en}, 32'h1);
    adv;
    check("R9 epc oldest open", epc, 32'h4);
    check("R9 cause irq", {29'b0, cause}, 32'h6);
    check("R7 handler after irq", fetch_pc, HANDLER);
    set_in(IRQ);
    check("R9 masked in handler", {31'b0, irq_take}, 32'h0);
    adv;
    set_in(RT); adv;
    check("R8 return after irq", fetch_pc, 32'h4);
    set_in(IRQ);
    check("R9 unmasked", {31'b0, irq_take}, 32'h1);
    adv;
    check("R9 epc from fetch_pc", epc, 32'h4);
  endtask

  task automatic t_collide;
    do_reset;
    set_in(F); adv;
    set_in(9'h0); adv;
    set_in(9'h0); adv;
    set_in(MPF | IRQ);
    check("R10 exc wins", {31'b0, exc_take}, 32'h1);
    check("R10 irq deferred", {31'b0, irq_take}, 32'h0);
    adv;
    check("R10 cause exc", {29'b0, cause}, 32'h4);
    set_in(RT | IRQ);
    check("R10 return wins", {31'b0, irq_take}, 32'h0);
    adv;
    check("R10 return pc", fetch_pc, 32'h0);
    set_in(IRQ);
    check("R10 irq later", {31'b0, irq_take}, 32'h1);
    adv;
    check("R10 cause irq later", {29'b0, cause}, 32'h6);
    set_in(9'h0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    set_in(9'h0);
    #1;
    t_reset_and_seq;
    t_fetch_fault_and_return;
    t_single(IFF | IDL | EXD | MPF, 3'd1);
    t_single(IDL | EXD, 3'd2);
    t_single(EXD | MPR, 3'd3);
    t_single(MPF | MPR, 3'd4);
    t_single(MPR, 3'd5);
    t_order;
    t_interrupt;
    t_collide;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule